// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache

This block places a small direct-mapped cache between a CPU request port and a slower main-memory port. The memory holds 32 words, and the cache holds 8 lines of one word each. The low three address bits pick a line, and the upper two bits are kept as that line's tag. Each line also carries a valid flag and a dirty flag.

CPU writes land only in the cache and mark the line dirty. Main memory learns about a changed word only when a miss needs that line for a different address. Before the line is reused, the old word is pushed back to memory at the address rebuilt from the stored tag and the line index.

The CPU raises a request and holds it, together with its address, write flag and write data, until the block answers with a one-cycle done pulse. The hit and write-back flags are valid during that pulse, and so is the read data for reads. Each memory transfer is a request that the memory side completes with a one-cycle acknowledge.

Top module: `wbc_cache`

## Requirements
- R1: After reset every line is invalid and clean, so the first access to any address is a miss that reports no write-back. No done pulse or memory request is active while idle after reset.
- R2: A read whose tag matches a valid line returns the stored word with `cpu_hit`=1. The done pulse comes in the first cycle after the request is sampled, and no memory transfer takes place.
- R3: A write hit replaces the word in the cache only and causes no memory transfer. A later read of the same address returns the new word.
- R4: A miss on an invalid line, or on a valid line that is not dirty, performs no memory write and reports `cpu_wb`=0.
- R5: A miss on a valid dirty line first performs exactly one memory write, before any memory read. The write goes to address {stored tag, index} and carries the stored word. The access reports `cpu_wb`=1.
- R6: A read miss performs one memory read at the requested address and returns the fetched word. The line is installed clean, so a later miss that evicts it performs no write-back.
- R7: A write miss performs no memory read. It installs the CPU word as a valid dirty line with the new tag.
- R8: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R9: `cpu_done` is a single-cycle pulse per accepted request. `cpu_hit` and `cpu_wb` are read during that pulse.
- R10: The line index is address bits [2:0] and the tag is bits [4:3]. Addresses that differ only in bits [4:3] compete for the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 5 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Read data, valid with done on reads |
| cpu_hit | output | 1 | Access hit, valid with done |
| cpu_wb | output | 1 | Access evicted a dirty word, valid with done |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 5 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory transfer complete, one cycle |
| mem_rdata | input | 16 | Memory read data, valid with ack |

## Verification
Some faults stay hidden while the word sits in the cache. A wrong dirty flag or a wrong stored tag shows up only when a later miss on the same line writes back or fails to write back. The bench therefore runs long conflicting address streams, so that a fault reaches the `mem_we`/`mem_addr`/`mem_wdata` transfer within a few accesses. A wrong word is caught on the next read of that address, whether it is served from the cache or from memory after an eviction. The bench keeps its own model of memory contents, so any lost write-back appears as stale read data.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned IDX_W  = 3;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned TAG_W  = ADDR_W - IDX_W;
    localparam int unsigned LINES  = 1 << IDX_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic  valid;
        logic  dirty;
        tag_t  tag;
        data_t data;
    } line_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2,
        ST_DONE  = 2'd3
    } state_e;

    function automatic idx_t idx_of(input addr_t a);
        return a[IDX_W-1:0];
    endfunction

    function automatic tag_t tag_of(input addr_t a);
        return a[ADDR_W-1:IDX_W];
    endfunction

    function automatic addr_t join_addr(input tag_t t, input idx_t i);
        return {t, i};
    endfunction
endpackage

// File: rtl/wbc_line_store.sv
module wbc_line_store
    import wbc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  idx_t  rd_idx,
    output line_t rd_line,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  line_t wr_line
);
    line_t line_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                line_q[g] <= '0;
            end else if (wr_en && wr_idx == idx_t'(g)) begin
                line_q[g] <= wr_line;
            end
        end
    end

    assign rd_line = line_q[rd_idx];
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
    import wbc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cpu_req,
    input  logic  cpu_we,
    input  addr_t cpu_addr,
    input  data_t cpu_wdata,
    output logic  cpu_done,
    output data_t cpu_rdata,
    output logic  cpu_hit,
    output logic  cpu_wb,
    output logic  mem_req,
    output logic  mem_we,
    output addr_t mem_addr,
    output data_t mem_wdata,
    input  logic  mem_ack,
    input  data_t mem_rdata,
    output idx_t  rd_idx,
    input  line_t rd_line,
    output logic  wr_en,
    output idx_t  wr_idx,
    output line_t wr_line
);
    state_e state_q, state_d;
    addr_t  addr_q;
    logic   we_q;
    data_t  wdata_q;
    data_t  rdata_q, rdata_d;
    logic   hit_q, hit_d;
    logic   wb_q, wb_d;

    addr_t  cur_addr;
    logic   look_hit;
    logic   victim_dirty;

    assign cur_addr     = (state_q == ST_IDLE) ? cpu_addr : addr_q;
    assign rd_idx       = idx_of(cur_addr);
    assign wr_idx       = rd_idx;
    assign look_hit     = rd_line.valid && (rd_line.tag == tag_of(cur_addr));
    assign victim_dirty = rd_line.valid && rd_line.dirty;

    always_comb begin
        state_d   = state_q;
        rdata_d   = rdata_q;
        hit_d     = hit_q;
        wb_d      = wb_q;
        wr_en     = 1'b0;
        wr_line   = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    hit_d = look_hit;
                    wb_d  = !look_hit && victim_dirty;
                    if (look_hit) begin
                        state_d = ST_DONE;
                        if (cpu_we) begin
                            wr_en         = 1'b1;
                            wr_line.valid = 1'b1;
                            wr_line.dirty = 1'b1;
                            wr_line.tag   = tag_of(cpu_addr);
                            wr_line.data  = cpu_wdata;
                        end else begin
                            rdata_d = rd_line.data;
                        end
                    end else if (victim_dirty) begin
                        state_d = ST_WBACK;
                    end else if (cpu_we) begin
                        wr_en         = 1'b1;
                        wr_line.valid = 1'b1;
                        wr_line.dirty = 1'b1;
                        wr_line.tag   = tag_of(cpu_addr);
                        wr_line.data  = cpu_wdata;
                        state_d       = ST_DONE;
                    end else begin
                        state_d = ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = join_addr(rd_line.tag, rd_idx);
                mem_wdata = rd_line.data;
                if (mem_ack) begin
                    if (we_q) begin
                        wr_en         = 1'b1;
                        wr_line.valid = 1'b1;
                        wr_line.dirty = 1'b1;
                        wr_line.tag   = tag_of(addr_q);
                        wr_line.data  = wdata_q;
                        state_d       = ST_DONE;
                    end else begin
                        state_d = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = addr_q;
                if (mem_ack) begin
                    wr_en         = 1'b1;
                    wr_line.valid = 1'b1;
                    wr_line.dirty = 1'b0;
                    wr_line.tag   = tag_of(addr_q);
                    wr_line.data  = mem_rdata;
                    rdata_d       = mem_rdata;
                    state_d       = ST_DONE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            hit_q   <= 1'b0;
            wb_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            rdata_q <= rdata_d;
            hit_q   <= hit_d;
            wb_q    <= wb_d;
            if (state_q == ST_IDLE && cpu_req) begin
                addr_q  <= cpu_addr;
                we_q    <= cpu_we;
                wdata_q <= cpu_wdata;
            end
        end
    end

    assign cpu_done  = (state_q == ST_DONE);
    assign cpu_rdata = rdata_q;
    assign cpu_hit   = hit_q;
    assign cpu_wb    = wb_q;
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
    import wbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_hit,
    output logic              cpu_wb,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    idx_t  rd_idx;
    line_t rd_line;
    logic  wr_en;
    idx_t  wr_idx;
    line_t wr_line;

    wbc_line_store u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (rd_idx),
        .rd_line (rd_line),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_line (wr_line)
    );

    wbc_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_done  (cpu_done),
        .cpu_rdata (cpu_rdata),
        .cpu_hit   (cpu_hit),
        .cpu_wb    (cpu_wb),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .rd_idx    (rd_idx),
        .rd_line   (rd_line),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_line   (wr_line)
    );
endmodule

// File: rtl/wbc_cache_chk.sv
module wbc_cache_chk
    import wbc_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  cpu_done,
    input logic  cpu_hit,
    input logic  cpu_wb,
    input logic  mem_req,
    input logic  mem_we,
    input addr_t mem_addr,
    input data_t mem_wdata,
    input logic  mem_ack
);
    logic saw_xfer;
    logic saw_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            saw_xfer  <= 1'b0;
            saw_write <= 1'b0;
        end else if (cpu_done) begin
            saw_xfer  <= 1'b0;
            saw_write <= 1'b0;
        end else if (mem_req && mem_ack) begin
            saw_xfer <= 1'b1;
            if (mem_we) saw_write <= 1'b1;
        end
    end

    p_hold_req_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

    p_hit_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_done && cpu_hit) |-> !saw_xfer);

    p_wb_flag_r5: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> (cpu_wb == saw_write));

    p_hit_no_wb_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_done && cpu_hit) |-> !cpu_wb);
endmodule

bind wbc_cache wbc_cache_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_done  (cpu_done),
    .cpu_hit   (cpu_hit),
    .cpu_wb    (cpu_wb),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/wbc_cache_bench.sv
module wbc_cache_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_req, cpu_we;
    logic [4:0]  cpu_addr;
    logic [15:0] cpu_wdata;
    logic        cpu_done, cpu_hit, cpu_wb;
    logic [15:0] cpu_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [4:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;

    logic [15:0] mem_model [32];
    logic        m_v [8];
    logic        m_d [8];
    logic [1:0]  m_t [8];
    logic [15:0] m_dat [8];

    int          n_wr, n_rd, lat;
    logic [4:0]  wr_addr_log, rd_addr_log;
    logic [15:0] wr_data_log;
    logic        order_bad;

    wbc_cache u_wbc_cache (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cpu_wb(cpu_wb),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [15:0] init_word(input int a);
        return 16'(a * 16'h0123 + 16'h0A05);
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory responder: random latency, one-cycle ack
    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
        lat = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (lat == 0) lat = 1 + int'($urandom % 3);
                lat--;
                if (lat == 0) begin
                    if (mem_we) begin
                        n_wr++;
                        wr_addr_log = mem_addr;
                        wr_data_log = mem_wdata;
                        mem_model[mem_addr] = mem_wdata;
                        if (n_rd > 0) order_bad = 1'b1;
                    end else begin
                        n_rd++;
                        rd_addr_log = mem_addr;
                        mem_rdata = mem_model[mem_addr];
                    end
                    mem_ack = 1'b1;
                end
            end
        end
    end

    task automatic access(input logic we, input logic [4:0] addr, input logic [15:0] wd);
        int idx = int'(addr[2:0]);
        logic [1:0] tg = addr[4:3];
        logic exp_hit = m_v[idx] && (m_t[idx] == tg);
        logic exp_wb = !exp_hit && m_v[idx] && m_d[idx];
        logic [4:0] exp_wb_addr = {m_t[idx], addr[2:0]};
        logic [15:0] exp_wb_data = m_dat[idx];
        logic [15:0] exp_rd = exp_hit ? m_dat[idx] : mem_model[addr];
        int cyc = 0;
        logic done_seen = 1'b0;
        @(negedge clk);
        n_wr = 0; n_rd = 0; order_bad = 1'b0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            cyc++;
            if (cpu_done) begin done_seen = 1'b1; break; end
        end
        chk(done_seen, "R9", "done pulse seen", int'(done_seen), 1);
        chk(cpu_hit == exp_hit, "R10", "hit flag", int'(cpu_hit), int'(exp_hit));
        chk(cpu_wb == exp_wb, "R5", "write-back flag", int'(cpu_wb), int'(exp_wb));
        if (exp_hit) begin
            chk(cyc == 1, "R2", "hit latency", cyc, 1);
            chk(n_wr + n_rd == 0, we ? "R3" : "R2", "memory transfers on hit", n_wr + n_rd, 0);
        end
        if (exp_wb) begin
            chk(n_wr == 1 && wr_addr_log == exp_wb_addr, "R5", "victim address",
                int'(wr_addr_log), int'(exp_wb_addr));
            chk(wr_data_log == exp_wb_data, "R5", "victim data",
                int'(wr_data_log), int'(exp_wb_data));
            chk(!order_bad, "R5", "write-back before fill", int'(order_bad), 0);
        end else begin
            chk(n_wr == 0, "R4", "memory writes", n_wr, 0);
        end
        if (!exp_hit && we)
            chk(n_rd == 0, "R7", "memory reads on write miss", n_rd, 0);
        if (!exp_hit && !we)
            chk(n_rd == 1 && rd_addr_log == addr, "R6", "fill address",
                int'(rd_addr_log), int'(addr));
        if (!we)
            chk(cpu_rdata == exp_rd, exp_hit ? "R2" : "R6", "read data",
                int'(cpu_rdata), int'(exp_rd));
        cpu_req = 1'b0;
        @(negedge clk);
        chk(!cpu_done, "R9", "done single cycle", int'(cpu_done), 0);
        // update reference model
        if (we) begin
            m_v[idx] = 1'b1; m_d[idx] = 1'b1; m_t[idx] = tg; m_dat[idx] = wd;
        end else if (!exp_hit) begin
            m_v[idx] = 1'b1; m_d[idx] = 1'b0; m_t[idx] = tg; m_dat[idx] = exp_rd;
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20061));
        for (int a = 0; a < 32; a++) mem_model[a] = init_word(a);
        for (int i = 0; i < 8; i++) begin
            m_v[i] = 1'b0; m_d[i] = 1'b0; m_t[i] = '0; m_dat[i] = '0;
        end
        rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        n_wr = 0; n_rd = 0; order_bad = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(!cpu_done, "R1", "done after reset", int'(cpu_done), 0);
        chk(!mem_req, "R1", "mem_req after reset", int'(mem_req), 0);

        // R1: first access is a clean miss
        access(1'b0, 5'b00011, '0);
        // R7 then R3: write miss installs, write hit updates cache only
        access(1'b1, 5'b00001, 16'h0123);
        access(1'b1, 5'b00001, 16'h0456);
        access(1'b0, 5'b00001, '0);
        // R10/R5: conflicting tag on dirty line forces write-back
        access(1'b1, 5'b11001, 16'h0555);
        access(1'b0, 5'b00001, '0);
        // R6: clean line from read miss evicted without write-back
        access(1'b0, 5'b10011, '0);
        access(1'b1, 5'b01111, 16'h0AAA);
        access(1'b0, 5'b11111, '0);

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [4:0] a = 5'($urandom % 32);
            logic w = ($urandom % 2) == 1;
            access(w, a, 16'($urandom));
        end
        // sweep: every address read back matches expected memory image
        for (int a = 0; a < 32; a++) access(1'b0, 5'(a), '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule